// File: doc/BRIEF.md
# Address-Aware Shared SRAM Arbiter

This block lets two requesters share one single-port synchronous SRAM. One requester is the system-bus side and the other is a FIFO loader that streams memory contents out. Each requester raises a request and keeps its read/write flag, address and write data steady until it is granted. Its access takes place in a cycle where its own grant is high and the other grant is low. The grants are registered, so the arbiter decides from the requests in one cycle and shows the result in the next. In that granted cycle the memory port carries the winner's address, write enable and write data straight through.

When both requesters contend, the winner depends on the two addresses and on the history of previous conflicts, not on a fixed rotation. The FIFO loader takes every conflict on a shared address. On differing addresses the bus side wins when nobody is waiting from an earlier loss. Otherwise the requester that lost the previous conflict goes next. A requester that was only held up while the other side owned the port gets no such priority.

Top module: `ram_arb`

## Requirements
- R1: With no request in a cycle, both grants are high in the next cycle, and the memory is not enabled in any cycle where both grants are high.
- R2: When exactly one requester asks in a cycle, the next cycle shows its grant high and the other grant low (grant bus_gnt is bit 0 and fifo_gnt is bit 1 of the internal grant code).
- R3: When both ask with equal addresses, the next cycle grants the FIFO side only, even if the bus side lost the conflict before.
- R4: When both ask with differing addresses and no requester is waiting from a lost conflict, the next cycle grants the bus side only.
- R5: When both ask with differing addresses and one requester lost the previous conflict, that requester is granted next. A requester that was only waiting while the other side held an exclusive grant gains no priority.
- R6: A requester's lost-conflict state is cleared in any cycle where it is granted or does not request.
- R7: In a cycle where exactly one grant is high and that requester's request is high, mem_en is high and mem_we, mem_addr and mem_wdata equal that requester's write flag, address and write data. In every other cycle mem_en is low.
- R8: In the cycle after any request is present, at most one grant is high.
- R9: A synchronous active-high reset sets both grants high and clears all lost-conflict state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Bus-side request |
| bus_we | input | 1 | Bus-side write flag (1 = write) |
| bus_addr | input | ADDR_W | Bus-side address |
| bus_wdata | input | DATA_W | Bus-side write data |
| bus_gnt | output | 1 | Bus-side grant (registered) |
| fifo_req | input | 1 | FIFO-loader request |
| fifo_we | input | 1 | FIFO-loader write flag (1 = write) |
| fifo_addr | input | ADDR_W | FIFO-loader address |
| fifo_wdata | input | DATA_W | FIFO-loader write data |
| fifo_gnt | output | 1 | FIFO-loader grant (registered) |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |

## Verification
If a lost-conflict flag is set or cleared wrongly, nothing shows while the two sides do not contend. The fault appears only at the next differing-address conflict, as the wrong grant one cycle after the contested requests. The bench therefore separates conflicts with idle and lone-request cycles, so a stale flag is caught at that later point. A bad grant register or a wrong memory multiplexer shows at once in the granted cycle. The scoreboard then sees a memory access with the wrong address, data or write flag, or an access that should not happen.

// File: rtl/ram_arb_pkg.sv
package ram_arb_pkg;
  // bit 0: bus side owns the port, bit 1: FIFO side owns the port
  typedef enum logic [1:0] {
    GNT_NONE = 2'b00,
    GNT_BUS  = 2'b01,
    GNT_FIFO = 2'b10,
    GNT_OPEN = 2'b11
  } gnt_e;
endpackage

// File: rtl/arb_decide.sv
module arb_decide
  import ram_arb_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              bus_req,
  input  logic              fifo_req,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [ADDR_W-1:0] fifo_addr,
  input  logic              bus_lost,
  input  logic              fifo_lost,
  output gnt_e              nxt,
  output logic              bus_won,
  output logic              fifo_won
);
  logic same_addr;
  assign same_addr = (bus_addr == fifo_addr);

  always_comb begin
    nxt = GNT_OPEN;
    unique case ({fifo_req, bus_req})
      2'b00: nxt = GNT_OPEN;
      2'b01: nxt = GNT_BUS;
      2'b10: nxt = GNT_FIFO;
      default: begin
        if (same_addr)      nxt = GNT_FIFO;  // shared location: loader first
        else if (bus_lost)  nxt = GNT_BUS;
        else if (fifo_lost) nxt = GNT_FIFO;
        else                nxt = GNT_BUS;   // fresh conflict
      end
    endcase
  end

  assign bus_won  = (nxt == GNT_BUS);
  assign fifo_won = (nxt == GNT_FIFO);
endmodule

// File: rtl/arb_lost_flag.sv
module arb_lost_flag (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic won,
  input  logic rival_won,
  output logic lost
);
  // set only when this side asked and the rival was picked
  always_ff @(posedge clk) begin
    if (rst) lost <= 1'b0;
    else     lost <= req & ~won & rival_won;
  end

  a_r6_clear_on_win : assert property (@(posedge clk) disable iff (rst)
    (won || !req) |=> !lost);
endmodule

// File: rtl/arb_grant_reg.sv
module arb_grant_reg
  import ram_arb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  gnt_e nxt,
  output gnt_e gnt_q
);
  always_ff @(posedge clk) begin
    if (rst) gnt_q <= GNT_OPEN;
    else     gnt_q <= nxt;
  end
endmodule

// File: rtl/arb_mem_mux.sv
module arb_mem_mux
  import ram_arb_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  gnt_e              gnt,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              fifo_req,
  input  logic              fifo_we,
  input  logic [ADDR_W-1:0] fifo_addr,
  input  logic [DATA_W-1:0] fifo_wdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = bus_addr;
    mem_wdata = bus_wdata;
    unique case (gnt)
      GNT_BUS: begin
        mem_en    = bus_req;
        mem_we    = bus_req & bus_we;
        mem_addr  = bus_addr;
        mem_wdata = bus_wdata;
      end
      GNT_FIFO: begin
        mem_en    = fifo_req;
        mem_we    = fifo_req & fifo_we;
        mem_addr  = fifo_addr;
        mem_wdata = fifo_wdata;
      end
      default: ;  // open or none: port idle
    endcase
  end
endmodule

// File: rtl/ram_arb.sv
module ram_arb
  import ram_arb_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              bus_gnt,
  input  logic              fifo_req,
  input  logic              fifo_we,
  input  logic [ADDR_W-1:0] fifo_addr,
  input  logic [DATA_W-1:0] fifo_wdata,
  output logic              fifo_gnt,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  gnt_e nxt, gnt_q;
  logic bus_won, fifo_won, bus_lost, fifo_lost;

  arb_decide #(.ADDR_W(ADDR_W)) u_decide (
    .bus_req(bus_req), .fifo_req(fifo_req),
    .bus_addr(bus_addr), .fifo_addr(fifo_addr),
    .bus_lost(bus_lost), .fifo_lost(fifo_lost),
    .nxt(nxt), .bus_won(bus_won), .fifo_won(fifo_won)
  );

  arb_lost_flag u_bus_lost (
    .clk(clk), .rst(rst), .req(bus_req), .won(bus_won),
    .rival_won(fifo_won), .lost(bus_lost)
  );

  arb_lost_flag u_fifo_lost (
    .clk(clk), .rst(rst), .req(fifo_req), .won(fifo_won),
    .rival_won(bus_won), .lost(fifo_lost)
  );

  arb_grant_reg u_gnt (
    .clk(clk), .rst(rst), .nxt(nxt), .gnt_q(gnt_q)
  );

  assign bus_gnt  = gnt_q[0];
  assign fifo_gnt = gnt_q[1];

  arb_mem_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
    .gnt(gnt_q),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .fifo_req(fifo_req), .fifo_we(fifo_we), .fifo_addr(fifo_addr), .fifo_wdata(fifo_wdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  a_r1_idle_open : assert property (@(posedge clk) disable iff (rst)
    (!bus_req && !fifo_req) |=> (bus_gnt && fifo_gnt));

  a_r1_no_mem_when_open : assert property (@(posedge clk) disable iff (rst)
    (bus_gnt && fifo_gnt) |-> !mem_en);

  a_r2_lone_bus : assert property (@(posedge clk) disable iff (rst)
    (bus_req && !fifo_req) |=> (bus_gnt && !fifo_gnt));

  a_r2_lone_fifo : assert property (@(posedge clk) disable iff (rst)
    (fifo_req && !bus_req) |=> (fifo_gnt && !bus_gnt));

  a_r3_equal_to_fifo : assert property (@(posedge clk) disable iff (rst)
    (bus_req && fifo_req && bus_addr == fifo_addr) |=> (fifo_gnt && !bus_gnt));

  a_r5_loser_next : assert property (@(posedge clk) disable iff (rst)
    (fifo_lost && bus_req && fifo_req && bus_addr != fifo_addr) |=> fifo_gnt);

  a_r6_single_loser : assert property (@(posedge clk) disable iff (rst)
    !(bus_lost && fifo_lost));

  a_r7_mem_follows_bus : assert property (@(posedge clk) disable iff (rst)
    (mem_en && bus_gnt && !fifo_gnt) |-> (mem_addr == bus_addr && mem_we == bus_we));

  a_r8_single_grant : assert property (@(posedge clk) disable iff (rst)
    (bus_req || fifo_req) |=> !(bus_gnt && fifo_gnt));
endmodule

// File: tb/tb_ram_arb.sv
module tb_ram_arb;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;

  typedef struct packed {
    logic              we;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } op_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_req = 0, bus_we = 0, fifo_req = 0, fifo_we = 0;
  logic [ADDR_W-1:0] bus_addr = '0, fifo_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0, fifo_wdata = '0;
  logic bus_gnt, fifo_gnt, mem_en, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  op_t exp_q[$];

  // reference state kept from the requirements
  logic [1:0] eg;
  logic lb, lf;

  always #5 clk = ~clk;

  ram_arb #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst(rst),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_gnt(bus_gnt),
    .fifo_req(fifo_req), .fifo_we(fifo_we), .fifo_addr(fifo_addr), .fifo_wdata(fifo_wdata),
    .fifo_gnt(fifo_gnt),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  // monitor: every memory access must match the next expected one (R7)
  always @(posedge clk) begin
    if (!rst && mem_en) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R7 unexpected access we=%0b addr=%0d, expected none", mem_we, mem_addr);
      end else begin
        op_t e;
        e = exp_q.pop_front();
        if (mem_we !== e.we || mem_addr !== e.addr || (e.we && mem_wdata !== e.data)) begin
          errors++;
          $display("FAIL R7 access we=%0b addr=%0d data=%0h, expected we=%0b addr=%0d data=%0h",
                   mem_we, mem_addr, mem_wdata, e.we, e.addr, e.data);
        end
      end
    end
  end

  task automatic step(input logic b, input logic bw, input int ba, input int bd,
                      input logic f, input int fa, input string tag);
    logic [1:0] nx;
    op_t o;
    @(negedge clk);
    bus_req = b; bus_we = bw; bus_addr = ADDR_W'(ba); bus_wdata = DATA_W'(bd);
    fifo_req = f; fifo_we = 1'b0; fifo_addr = ADDR_W'(fa); fifo_wdata = '0;
    #1;
    checks++;
    if ({fifo_gnt, bus_gnt} !== eg) begin
      errors++;
      $display("FAIL %s grants fifo,bus=%b%b, expected %b", tag, fifo_gnt, bus_gnt, eg);
    end
    if (eg == 2'b01 && b) begin
      o.we = bw; o.addr = ADDR_W'(ba); o.data = DATA_W'(bd); exp_q.push_back(o);
    end else if (eg == 2'b10 && f) begin
      o.we = 1'b0; o.addr = ADDR_W'(fa); o.data = '0; exp_q.push_back(o);
    end else begin
      checks++;
      if (mem_en !== 1'b0) begin
        errors++;
        $display("FAIL R1 mem_en=%b, expected 0 (%s)", mem_en, tag);
      end
    end
    // next grant from the arbitration rules R1-style per requirement
    if (!b && !f)                nx = 2'b11;
    else if (b && !f)            nx = 2'b01;
    else if (f && !b)            nx = 2'b10;
    else if (ba == fa)           nx = 2'b10;
    else if (lb)                 nx = 2'b01;
    else if (lf)                 nx = 2'b10;
    else                         nx = 2'b01;
    lb = b && f && (nx == 2'b10);
    lf = b && f && (nx == 2'b01);
    eg = nx;
  endtask

  task automatic reset_pulse();
    @(negedge clk);
    rst = 1'b1;
    bus_req = 1'b1; fifo_req = 1'b1; bus_addr = 10'd1; fifo_addr = 10'd2;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    bus_req = 1'b0; fifo_req = 1'b0;
    eg = 2'b11; lb = 1'b0; lf = 1'b0;
    #1;
    checks++;
    if ({fifo_gnt, bus_gnt} !== 2'b11) begin
      errors++;
      $display("FAIL R9 grants after reset %b%b, expected 11", fifo_gnt, bus_gnt);
    end
  endtask

  initial begin
    eg = 2'b11; lb = 1'b0; lf = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    step(0,0,0,0,       0,0, "R9 reset state");
    step(1,1,5,'h11,    0,0, "R1 idle opens both");
    step(1,1,5,'h11,    0,0, "R2 lone bus");
    step(0,0,0,0,       0,0, "R2 bus grant held one cycle");
    step(0,0,0,0,       1,7, "R1 idle opens both");
    step(0,0,0,0,       1,7, "R2 lone fifo");
    step(1,1,3,'h22,    1,3, "R2 fifo after lone request");
    step(1,1,3,'h22,    1,3, "R3 equal address to fifo");
    step(1,1,4,'h33,    1,9, "R3 equal address to fifo again");
    step(1,1,4,'h33,    1,9, "R5 bus lost equal conflict");
    step(1,1,4,'h33,    1,9, "R5 fifo lost, goes next");
    step(0,0,0,0,       0,0, "R5 alternation");
    step(1,1,6,'h44,    1,8, "R1 open after idle");
    step(0,0,0,0,       1,8, "R4 fresh differing conflict to bus");
    step(0,0,0,0,       0,0, "R2 lone fifo clears lost");
    step(1,1,6,'h44,    1,8, "R1 open after idle");
    step(1,1,6,'h44,    0,0, "R6 cleared flag: bus wins again");
    step(1,1,1,'h55,    1,2, "R2 lone bus");
    step(1,1,1,'h55,    1,2, "R5 waiting without loss gives no priority");
    step(1,1,2,'h66,    1,2, "R5 fifo lost, goes next");
    step(1,1,2,'h66,    1,2, "R3 equal beats bus waiting");
    step(1,1,2,'h66,    1,2, "R3 equal beats bus waiting again");
    reset_pulse();
    step(1,1,7,'h77,    1,5, "R9 open after reset");
    step(0,0,0,0,       0,0, "R9 cleared flags: bus wins");
    step(0,0,0,0,       0,0, "R8 idle reopens");
    @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R7 %0d expected accesses missing, expected 0", exp_q.size());
    end
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog R1 run did not end, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule